// File: doc/BRIEF.md
# DMA Peripheral Request Router

This block sits in front of one DMA channel. It picks which on-chip peripheral request line may start that channel. The candidates are five timer compare flags, the ADC conversion-end flag, and the transmit-empty and receive-full flags of two serial ports. A 4-bit select code makes the choice. The chosen line raises the DMA trigger only while the channel and the controller are both enabled and no stop condition (transfer end, NMI, address error) is pending. The trigger is registered, so it follows one clock after its conditions are present.

While a peripheral is routed to the DMA channel, its interrupt toward the CPU is withheld. All other peripherals forward their enabled interrupts unchanged. When the data mover reports a finished transfer, the router sends a one-cycle clear pulse back to the routed peripheral's flag. In cycle-steal mode this happens on every completed transfer. In burst mode it happens only on the last one.

The router also checks the programmed source and destination address classes against the register that the chosen request demands, and flags any mismatch combinationally.

Top module: `dmaReqRouter`

## Requirements
- R1: `dmaTrig` is 1 in a cycle only if, at the previous rising edge, `chanEn`=1, `masterEn`=1, `xferEnd`=0, `nmiFlag`=0, `addrErr`=0 and the selected request was live. Reset drives it to 0.
- R2: Select codes 6..10 route timer compare lines 0..4 (`periphReq` bits 0..4). Code 11 routes the ADC (bit 5). Codes 12/13 route port 0 transmit-empty and receive-full (bits 6/7). Codes 14/15 route port 1 transmit-empty and receive-full (bits 8/9). With the gate open, `dmaTrig` equals the registered value of the selected live request.
- R3: Select codes 0..5 route nothing. `dmaTrig` and `reqClr` stay 0 and no interrupt is withheld.
- R4: Address class codes are 0 memory, 1 ADC result, 2 port 0 receive data, 3 port 0 transmit data, 4 port 1 receive data, 5 port 1 transmit data. With code 11, 13 or 15, `cfgErr` is 1 exactly when `srcClass` is not 1, 2 or 4 respectively.
- R5: With code 12 or 14, `cfgErr` is 1 exactly when `dstClass` is not 3 or 5 respectively. All other codes give `cfgErr`=0.
- R6: `cpuIrq` equals the live requests with the routed peripheral's bit forced to 0.
- R7: In cycle-steal mode (`burstMode`=0), `xferDone` sampled high makes `reqClr` a one-hot pulse on the routed bit in the next cycle. Otherwise `reqClr` is 0.
- R8: In burst mode (`burstMode`=1), the clear pulse is sent only when `xferDone` and `lastXfer` are both sampled high.
- R9: A request line counts as live only while its `periphIntEn` bit is 1. A disabled line neither triggers the DMA nor reaches `cpuIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqSel | input | 4 | Request select code |
| chanEn | input | 1 | Channel enable |
| masterEn | input | 1 | Controller-wide enable |
| xferEnd | input | 1 | Channel transfer-end flag |
| nmiFlag | input | 1 | NMI stop flag |
| addrErr | input | 1 | Address-error stop flag |
| burstMode | input | 1 | 1 burst, 0 cycle steal |
| xferDone | input | 1 | One transfer completed |
| lastXfer | input | 1 | Completed transfer is the final one |
| srcClass | input | 3 | Class of programmed source address |
| dstClass | input | 3 | Class of programmed destination address |
| periphReq | input | 10 | Peripheral request/interrupt flags |
| periphIntEn | input | 10 | Per-peripheral interrupt enables |
| dmaTrig | output | 1 | Registered DMA trigger |
| reqClr | output | 10 | One-cycle clear pulse to the routed flag |
| cpuIrq | output | 10 | Interrupts forwarded to the CPU |
| cfgErr | output | 1 | Source/destination mismatch for the selected request |

## Verification
A wrong select decode shows in the same cycle as a withheld or leaked bit on `cpuIrq`. One edge later it also shows as a trigger or clear pulse on the wrong peripheral. A stuck or mis-gated trigger register shows one cycle after the gate inputs change. A wrong burst/cycle-steal choice shows as a missing or extra `reqClr` pulse one cycle after a `xferDone` strobe. The bench compares every output every cycle against values it computes from the sampled inputs, so any of these faults shows within one or two cycles.

// File: rtl/dmaRouterPkg.sv
package dmaRouterPkg;
  localparam int SEL_W     = 4;
  localparam int CLASS_W   = 3;
  localparam int TMR_COUNT = 5;
  localparam int REQ_COUNT = TMR_COUNT + 5;
  localparam int REQ_BASE  = (1 << SEL_W) - REQ_COUNT;
  localparam int IDX_ADC   = TMR_COUNT;
  localparam int IDX_TX0   = TMR_COUNT + 1;
  localparam int IDX_RX0   = TMR_COUNT + 2;
  localparam int IDX_TX1   = TMR_COUNT + 3;
  localparam int IDX_RX1   = TMR_COUNT + 4;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM = 3'd0,
    CLS_ADC = 3'd1,
    CLS_RX0 = 3'd2,
    CLS_TX0 = 3'd3,
    CLS_RX1 = 3'd4,
    CLS_TX1 = 3'd5
  } addrClass_e;

  typedef struct packed {
    logic                 selValid;
    logic [REQ_COUNT-1:0] selHot;
    logic                 gateOk;
    logic                 clrFire;
  } routeCtl_t;
endpackage

// File: rtl/dmaRouterCtrl.sv
module dmaRouterCtrl
  import dmaRouterPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic               chanEn,
  input  logic               masterEn,
  input  logic               xferEnd,
  input  logic               nmiFlag,
  input  logic               addrErr,
  input  logic               burstMode,
  input  logic               xferDone,
  input  logic               lastXfer,
  input  logic [CLASS_W-1:0] srcClass,
  input  logic [CLASS_W-1:0] dstClass,
  output routeCtl_t          ctl,
  output logic               cfgErr
);
  logic [REQ_COUNT-1:0] hot;

  // One decode comparator per routable request line
  for (genvar i = 0; i < REQ_COUNT; i++) begin : g_dec
    assign hot[i] = (reqSel == SEL_W'(REQ_BASE + i));
  end

  always_comb begin
    ctl.selHot   = hot;
    ctl.selValid = |hot;
    ctl.gateOk   = chanEn & masterEn & ~xferEnd & ~nmiFlag & ~addrErr;
    ctl.clrFire  = ctl.selValid & xferDone & (~burstMode | lastXfer);
  end

  // Register-binding check for serial and ADC requests
  always_comb begin
    cfgErr = 1'b0;
    if (hot[IDX_ADC]) cfgErr = (srcClass != CLS_ADC);
    if (hot[IDX_TX0]) cfgErr = (dstClass != CLS_TX0);
    if (hot[IDX_RX0]) cfgErr = (srcClass != CLS_RX0);
    if (hot[IDX_TX1]) cfgErr = (dstClass != CLS_TX1);
    if (hot[IDX_RX1]) cfgErr = (srcClass != CLS_RX1);
  end

  p_burst_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrFire && burstMode) |-> lastXfer);

  p_cfg_scope_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (reqSel >= SEL_W'(REQ_BASE + IDX_ADC)));

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.selHot));
endmodule

// File: rtl/dmaRouterDatapath.sv
module dmaRouterDatapath
  import dmaRouterPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  routeCtl_t            ctl,
  input  logic [REQ_COUNT-1:0] periphReq,
  input  logic [REQ_COUNT-1:0] periphIntEn,
  output logic                 dmaTrig,
  output logic [REQ_COUNT-1:0] reqClr,
  output logic [REQ_COUNT-1:0] cpuIrq
);
  logic [REQ_COUNT-1:0] liveReq;

  assign liveReq = periphReq & periphIntEn;
  assign cpuIrq  = liveReq & ~ctl.selHot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaTrig <= 1'b0;
      reqClr  <= '0;
    end else begin
      dmaTrig <= ctl.gateOk & |(liveReq & ctl.selHot);
      reqClr  <= ctl.clrFire ? ctl.selHot : '0;
    end
  end

  p_trig_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    dmaTrig |-> $past(ctl.gateOk));

  p_trig_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    dmaTrig |-> $past(|(periphReq & periphIntEn & ctl.selHot)));

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqClr));

  p_clr_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|reqClr) |-> $past(ctl.clrFire));

  p_irq_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq & ~periphIntEn) == '0);
endmodule

// File: rtl/dmaReqRouter.sv
module dmaReqRouter
  import dmaRouterPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     reqSel,
  input  logic                 chanEn,
  input  logic                 masterEn,
  input  logic                 xferEnd,
  input  logic                 nmiFlag,
  input  logic                 addrErr,
  input  logic                 burstMode,
  input  logic                 xferDone,
  input  logic                 lastXfer,
  input  logic [CLASS_W-1:0]   srcClass,
  input  logic [CLASS_W-1:0]   dstClass,
  input  logic [REQ_COUNT-1:0] periphReq,
  input  logic [REQ_COUNT-1:0] periphIntEn,
  output logic                 dmaTrig,
  output logic [REQ_COUNT-1:0] reqClr,
  output logic [REQ_COUNT-1:0] cpuIrq,
  output logic                 cfgErr
);
  routeCtl_t ctl;

  dmaRouterCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqSel(reqSel),
    .chanEn(chanEn), .masterEn(masterEn), .xferEnd(xferEnd),
    .nmiFlag(nmiFlag), .addrErr(addrErr), .burstMode(burstMode),
    .xferDone(xferDone), .lastXfer(lastXfer),
    .srcClass(srcClass), .dstClass(dstClass),
    .ctl(ctl), .cfgErr(cfgErr)
  );

  dmaRouterDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .periphReq(periphReq), .periphIntEn(periphIntEn),
    .dmaTrig(dmaTrig), .reqClr(reqClr), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/sim_dmaReqRouter.sv
module sim_dmaReqRouter;
  logic clk = 1'b0;
  logic rstN;
  logic [3:0] reqSel;
  logic chanEn, masterEn, xferEnd, nmiFlag, addrErr, burstMode, xferDone, lastXfer;
  logic [2:0] srcClass, dstClass;
  logic [9:0] periphReq, periphIntEn;
  logic dmaTrig, cfgErr;
  logic [9:0] reqClr, cpuIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  dmaReqRouter u0 (.*);

  function automatic logic [9:0] expHot(input logic [3:0] s);
    if (s >= 4'd6) return 10'b1 << (s - 4'd6);
    return '0;
  endfunction

  function automatic logic expErr(input logic [3:0] s, input logic [2:0] src, input logic [2:0] dst);
    case (s)
      4'd11: return src != 3'd1;
      4'd12: return dst != 3'd3;
      4'd13: return src != 3'd2;
      4'd14: return dst != 3'd5;
      4'd15: return src != 3'd4;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic expGate();
    return chanEn & masterEn & ~xferEnd & ~nmiFlag & ~addrErr;
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  logic       nextTrig;
  logic [9:0] nextClr;
  string      trigTag, clrTag;

  task automatic checkComb();
    logic [9:0] live;
    live = periphReq & periphIntEn;
    #1;
    check("R6 cpuIrq", cpuIrq, live & ~expHot(reqSel));
    check("R9 cpuIrq disabled lines", cpuIrq & ~periphIntEn, '0);
    if (reqSel inside {4'd12, 4'd14}) check("R5 cfgErr", {9'b0, cfgErr}, {9'b0, expErr(reqSel, srcClass, dstClass)});
    else check("R4 cfgErr", {9'b0, cfgErr}, {9'b0, expErr(reqSel, srcClass, dstClass)});
    nextTrig = expGate() & |(live & expHot(reqSel));
    nextClr  = (xferDone & (~burstMode | lastXfer)) ? expHot(reqSel) : '0;
    trigTag  = (expHot(reqSel) == 0) ? "R3 dmaTrig" : (expGate() ? "R2 dmaTrig" : "R1 dmaTrig");
    clrTag   = (expHot(reqSel) == 0) ? "R3 reqClr" : (burstMode ? "R8 reqClr" : "R7 reqClr");
  endtask

  task automatic checkRegs();
    check(trigTag, {9'b0, dmaTrig}, {9'b0, nextTrig});
    check(clrTag, reqClr, nextClr);
  endtask

  task automatic drive(input logic [3:0] s, input logic [9:0] rq, input logic [9:0] ie,
                       input logic gate, input logic bm, input logic dn, input logic lst,
                       input logic [2:0] sc, input logic [2:0] dc);
    reqSel = s; periphReq = rq; periphIntEn = ie;
    chanEn = gate; masterEn = 1'b1; xferEnd = 1'b0; nmiFlag = 1'b0; addrErr = 1'b0;
    burstMode = bm; xferDone = dn; lastXfer = lst; srcClass = sc; dstClass = dc;
  endtask

  task automatic step();
    @(negedge clk);
    checkRegs();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0;
    drive(4'd0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
    repeat (3) @(negedge clk);
    check("R1 reset dmaTrig", {9'b0, dmaTrig}, 10'b0);
    check("R7 reset reqClr", reqClr, '0);
    rstN = 1'b1;
    nextTrig = 1'b0; nextClr = '0; trigTag = "R1 dmaTrig"; clrTag = "R7 reqClr";

    // Directed: code 5 routes nothing even with everything live
    drive(4'd5, '1, '1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 3'd0); checkComb(); step();
    // Code 6 (timer 0) boundary
    drive(4'd6, 10'b1, '1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0); checkComb(); step();
    // Burst without last: no clear
    drive(4'd13, 10'b1 << 7, '1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 3'd0); checkComb(); step();
    // Burst with last: clear on port 0 receive
    drive(4'd13, 10'b1 << 7, '1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 3'd0); checkComb(); step();
    // Request with its enable off: no trigger
    drive(4'd11, 10'b1 << 5, '0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0); checkComb(); step();
    // Transmit destination mismatch
    drive(4'd14, 10'b1 << 8, '1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd3); checkComb(); step();

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] s;
      logic [2:0] sc, dc;
      s = ($urandom_range(0, 9) < 7) ? 4'($urandom_range(6, 15)) : 4'($urandom_range(0, 5));
      sc = ($urandom_range(0, 1) != 0) ? 3'($urandom_range(0, 5)) : 3'd1 + 3'(s[0] ? 1 : 0) + 3'(s == 4'd15 ? 2 : 0);
      dc = ($urandom_range(0, 1) != 0) ? 3'($urandom_range(0, 5)) : (s == 4'd14 ? 3'd5 : 3'd3);
      drive(s, 10'($urandom), 10'($urandom), 1'b1, 1'($urandom), ($urandom_range(0, 2) == 0),
            1'($urandom), sc, dc);
      chanEn   = ($urandom_range(0, 7) != 0);
      masterEn = ($urandom_range(0, 7) != 0);
      xferEnd  = ($urandom_range(0, 7) == 0);
      nmiFlag  = ($urandom_range(0, 7) == 0);
      addrErr  = ($urandom_range(0, 7) == 0);
      checkComb();
      step();
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule